// File: doc/BRIEF.md
# 2D Transfer Event Flag and Interrupt Unit

This block gathers the status events of a two-dimensional pixel-transfer engine and holds each one as a sticky flag. A single registered interrupt line combines the flags with a per-event enable mask. Four events arrive as one-cycle pulses from the datapath: configuration error, lookup-table load complete, transfer complete and bus error. The unit also derives two events itself. The first is a line watermark, found by comparing the datapath's pixel position against a programmed line number. The second is a lookup-table access conflict, found by watching CPU lookup-table strobes while the engine reports that it is busy.

Software uses a small register port with four addresses: the enable mask, the flag status, a write-one-to-clear register and the watermark line. A CPU lookup-table access that conflicts with engine activity is held back from the table and its read data is forced to zero. An access with no conflict passes straight through.

Top module: `blit_evt_irq`

## Requirements
- R1: After reset all six flags, the enable mask, the watermark line and `irq` are zero. The status register (address 1) shows the flags at bit 0 bus error, bit 1 transfer complete, bit 2 watermark, bit 3 lookup-table conflict, bit 4 lookup-table load complete and bit 5 configuration error.
- R2: A one-cycle pulse on `ev_bus_err`, `ev_xfer_done`, `ev_lut_done` or `ev_cfg_err` sets status bit 0, 1, 4 or 5 respectively at the next clock edge.
- R3: A cycle with `pix_valid` and `pix_eol` high and `line_idx` equal to the watermark register (address 3) sets status bit 2. Pixels that are not the last of that line, and last pixels of other lines, do not set it.
- R4: The watermark sets bit 2 at most once per transfer. A `xfer_start` pulse rearms it.
- R5: `cpu_lut_req` high while `lut_busy` is high sets status bit 3.
- R6: `cpu_lut_req` high while `xfer_busy` is high sets status bit 3.
- R7: During a conflicting access `lut_mem_req` stays low and `cpu_lut_rdata` is zero. Without a conflict `lut_mem_req` follows `cpu_lut_req` and `cpu_lut_rdata` equals `lut_mem_rdata`.
- R8: Flags are sticky. Writing the clear register (address 2) with bit k set clears flag k, zero bits have no effect, and the clear register reads as zero.
- R9: If a flag's set event and its clear fall in the same cycle, the flag ends up set.
- R10: `irq` is high one cycle after any flag and its enable bit (address 0, same bit positions) are both high, and low one cycle after no such pair remains.
- R11: The enable register and the watermark register read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Pulse at the start of a transfer; rearms the watermark |
| ev_cfg_err | input | 1 | Configuration error pulse |
| ev_lut_done | input | 1 | Lookup-table load complete pulse |
| ev_xfer_done | input | 1 | Transfer complete pulse |
| ev_bus_err | input | 1 | Bus master error response pulse |
| pix_valid | input | 1 | A pixel was transferred this cycle |
| pix_eol | input | 1 | That pixel is the last of its line |
| line_idx | input | LINE_W | Line number of the current pixel |
| lut_busy | input | 1 | Lookup-table load in progress |
| xfer_busy | input | 1 | Pixel transfer in progress |
| cpu_lut_req | input | 1 | CPU lookup-table access strobe |
| lut_mem_rdata | input | DATA_W | Read data from the lookup-table memory |
| lut_mem_req | output | 1 | Access strobe forwarded to the lookup-table memory |
| cpu_lut_rdata | output | DATA_W | Read data returned to the CPU |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The main collision is an event pulse setting a flag in the same cycle that a write-one-to-clear targets that flag. The vector table drives datapath pulses together with clear writes that overlap, partly overlap or miss them. After every row the status register is read back, and the expected value is accumulated from the set-wins rule. A second collision is a CPU lookup-table access that arrives while the engine is busy. There the forwarded strobe and the zeroed read data are sampled in the same cycle as the access, and the conflict flag is read one cycle later.

// File: rtl/blit_evt_pkg.sv
package blit_evt_pkg;
   localparam int NUM_EVT = 6;

   // Flag bit positions, visible to software in status/enable/clear
   localparam int EV_BUS_ERR      = 0;
   localparam int EV_XFER_DONE    = 1;
   localparam int EV_WMARK        = 2;
   localparam int EV_LUT_CONFLICT = 3;
   localparam int EV_LUT_DONE     = 4;
   localparam int EV_CFG_ERR      = 5;

   typedef enum logic [1:0] {
      RA_ENABLE = 2'd0,
      RA_STATUS = 2'd1,
      RA_CLEAR  = 2'd2,
      RA_WMARK  = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/blit_wmark_det.sv
module blit_wmark_det #(
   parameter int LINE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic              pix_valid,
   input  logic              pix_eol,
   input  logic [LINE_W-1:0] line_idx,
   input  logic [LINE_W-1:0] wm_line,
   output logic              hit
);
   logic fired_q;
   logic line_end_match;

   assign line_end_match = pix_valid && pix_eol && (line_idx == wm_line);
   assign hit            = line_end_match && !fired_q;

   // One shot per transfer; a new transfer rearms it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fired_q <= 1'b0;
      else if (hit)
         fired_q <= 1'b1;
      else if (xfer_start)
         fired_q <= 1'b0;
   end
endmodule

// File: rtl/blit_lut_guard.sv
module blit_lut_guard #(
   parameter int DATA_W = 32,
   parameter bit BLOCK_ON_CONFLICT = 1'b1
) (
   input  logic              cpu_lut_req,
   input  logic              lut_busy,
   input  logic              xfer_busy,
   input  logic [DATA_W-1:0] lut_mem_rdata,
   output logic              lut_mem_req,
   output logic [DATA_W-1:0] cpu_lut_rdata,
   output logic              conflict
);
   assign conflict = cpu_lut_req && (lut_busy || xfer_busy);

   generate
      if (BLOCK_ON_CONFLICT) begin : g_block
         assign lut_mem_req   = cpu_lut_req && !conflict;
         assign cpu_lut_rdata = conflict ? '0 : lut_mem_rdata;
      end else begin : g_pass
         assign lut_mem_req   = cpu_lut_req;
         assign cpu_lut_rdata = lut_mem_rdata;
      end
   endgenerate
endmodule

// File: rtl/blit_flag_bank.sv
module blit_flag_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] flags
);
   generate
      for (genvar k = 0; k < N; k++) begin : g_flag
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               f_q <= 1'b0;
            else if (set_vec[k])
               f_q <= 1'b1;      // set has priority over clear
            else if (clr_vec[k])
               f_q <= 1'b0;
         end
         assign flags[k] = f_q;
      end
   endgenerate
endmodule

// File: rtl/blit_evt_irq.sv
module blit_evt_irq
   import blit_evt_pkg::*;
#(
   parameter int LINE_W = 16,
   parameter int DATA_W = 32,
   parameter int REG_W  = 16,
   parameter bit BLOCK_ON_CONFLICT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_start,
   input  logic              ev_cfg_err,
   input  logic              ev_lut_done,
   input  logic              ev_xfer_done,
   input  logic              ev_bus_err,
   input  logic              pix_valid,
   input  logic              pix_eol,
   input  logic [LINE_W-1:0] line_idx,
   input  logic              lut_busy,
   input  logic              xfer_busy,
   input  logic              cpu_lut_req,
   input  logic [DATA_W-1:0] lut_mem_rdata,
   output logic              lut_mem_req,
   output logic [DATA_W-1:0] cpu_lut_rdata,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);
   generate
      if (REG_W < LINE_W) begin : g_chk_line
         $error("REG_W must hold the watermark line");
      end
      if (REG_W < NUM_EVT) begin : g_chk_evt
         $error("REG_W must hold all event flags");
      end
      if (DATA_W < 1) begin : g_chk_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [NUM_EVT-1:0] en_q;
   logic [NUM_EVT-1:0] flag_q;
   logic [NUM_EVT-1:0] set_vec;
   logic [NUM_EVT-1:0] clr_vec;
   logic [LINE_W-1:0]  wm_q;
   logic               wm_hit;
   logic               lut_conflict;
   logic               irq_q;

   blit_wmark_det #(.LINE_W(LINE_W)) u_wmark (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_start (xfer_start),
      .pix_valid  (pix_valid),
      .pix_eol    (pix_eol),
      .line_idx   (line_idx),
      .wm_line    (wm_q),
      .hit        (wm_hit)
   );

   blit_lut_guard #(.DATA_W(DATA_W), .BLOCK_ON_CONFLICT(BLOCK_ON_CONFLICT)) u_guard (
      .cpu_lut_req   (cpu_lut_req),
      .lut_busy      (lut_busy),
      .xfer_busy     (xfer_busy),
      .lut_mem_rdata (lut_mem_rdata),
      .lut_mem_req   (lut_mem_req),
      .cpu_lut_rdata (cpu_lut_rdata),
      .conflict      (lut_conflict)
   );

   always_comb begin
      set_vec                  = '0;
      set_vec[EV_BUS_ERR]      = ev_bus_err;
      set_vec[EV_XFER_DONE]    = ev_xfer_done;
      set_vec[EV_WMARK]        = wm_hit;
      set_vec[EV_LUT_CONFLICT] = lut_conflict;
      set_vec[EV_LUT_DONE]     = ev_lut_done;
      set_vec[EV_CFG_ERR]      = ev_cfg_err;
   end

   assign clr_vec = (reg_wr && reg_addr == RA_CLEAR) ? reg_wdata[NUM_EVT-1:0] : '0;

   blit_flag_bank #(.N(NUM_EVT)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .flags   (flag_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         wm_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == RA_ENABLE) en_q <= reg_wdata[NUM_EVT-1:0];
         if (reg_addr == RA_WMARK)  wm_q <= reg_wdata[LINE_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(flag_q & en_q);
   end
   assign irq = irq_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_ENABLE: reg_rdata[NUM_EVT-1:0] = en_q;
         RA_STATUS: reg_rdata[NUM_EVT-1:0] = flag_q;
         RA_WMARK:  reg_rdata[LINE_W-1:0]  = wm_q;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/blit_evt_irq_chk.sv
module blit_evt_irq_chk #(
   parameter int NUM_EVT = 6,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ev_bus_err,
   input logic               cpu_lut_req,
   input logic               lut_busy,
   input logic               xfer_busy,
   input logic               lut_mem_req,
   input logic [DATA_W-1:0]  cpu_lut_rdata,
   input logic [NUM_EVT-1:0] flag_q,
   input logic [NUM_EVT-1:0] en_q,
   input logic [NUM_EVT-1:0] set_vec,
   input logic [NUM_EVT-1:0] clr_vec,
   input logic               irq
);
   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   AST_BUS_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_bus_err |=> flag_q[0]); // R2

   AST_CONFLICT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_lut_req && lut_busy) |=> flag_q[3]); // R5

   AST_CONFLICT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_lut_req && xfer_busy) |=> flag_q[3]); // R6

   AST_CONFLICT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_lut_req && (lut_busy || xfer_busy)) |-> (!lut_mem_req && cpu_lut_rdata == '0)); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> ((($past(flag_q) & ~$past(clr_vec)) & ~flag_q) == '0)); // R8

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |-> (($past(set_vec) & ~flag_q) == '0)); // R9

   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flag_q & en_q)) |=> irq); // R10

   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(flag_q & en_q)) |=> !irq); // R10
endmodule

bind blit_evt_irq blit_evt_irq_chk #(.NUM_EVT(blit_evt_pkg::NUM_EVT), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_blit_evt_irq.sv
`timescale 1ns/1ps
module tb_blit_evt_irq;
   localparam int LINE_W = 16;
   localparam int DATA_W = 32;
   localparam int REG_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              xfer_start = 1'b0;
   logic              ev_cfg_err = 1'b0, ev_lut_done = 1'b0, ev_xfer_done = 1'b0, ev_bus_err = 1'b0;
   logic              pix_valid = 1'b0, pix_eol = 1'b0;
   logic [LINE_W-1:0] line_idx = '0;
   logic              lut_busy = 1'b0, xfer_busy = 1'b0, cpu_lut_req = 1'b0;
   logic [DATA_W-1:0] lut_mem_rdata = '0;
   logic              lut_mem_req;
   logic [DATA_W-1:0] cpu_lut_rdata;
   logic              reg_wr = 1'b0;
   logic [1:0]        reg_addr = 2'd0;
   logic [REG_W-1:0]  reg_wdata = '0;
   logic [REG_W-1:0]  reg_rdata;
   logic              irq;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   blit_evt_irq dut (.*);

   // {events[3:0] = cfg,lut_done,xfer_done,bus_err ; clear[5:0] ; expected status[5:0]}
   localparam int NV = 11;
   localparam logic [15:0] VEC [NV] = '{
      {4'b0001, 6'b000000, 6'b000001},
      {4'b0010, 6'b000000, 6'b000011},
      {4'b0100, 6'b000000, 6'b010011},
      {4'b1000, 6'b000000, 6'b110011},
      {4'b0000, 6'b000001, 6'b110010},
      {4'b0001, 6'b000001, 6'b110011},
      {4'b0000, 6'b110000, 6'b000011},
      {4'b0000, 6'b000000, 6'b000011},
      {4'b0000, 6'b111111, 6'b000000},
      {4'b1010, 6'b100000, 6'b100010},
      {4'b0000, 6'b111111, 6'b000000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [REG_W-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic pix(input logic [LINE_W-1:0] ln, input logic eol);
      pix_valid = 1'b1; pix_eol = eol; line_idx = ln;
      @(negedge clk);
      pix_valid = 1'b0; pix_eol = 1'b0;
   endtask

   task automatic start_xfer();
      xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [REG_W-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd1, d); chk("R1 status after reset", d, 0);
      rd(2'd0, d); chk("R1 enable after reset", d, 0);
      rd(2'd3, d); chk("R1 watermark after reset", d, 0);
      chk("R1 irq after reset", irq, 0);

      // R2 R8 R9 vector table
      for (int i = 0; i < NV; i++) begin
         ev_bus_err   = VEC[i][12];
         ev_xfer_done = VEC[i][13];
         ev_lut_done  = VEC[i][14];
         ev_cfg_err   = VEC[i][15];
         reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = {10'd0, VEC[i][11:6]};
         @(negedge clk);
         ev_bus_err = 0; ev_xfer_done = 0; ev_lut_done = 0; ev_cfg_err = 0;
         reg_wr = 1'b0; reg_wdata = '0;
         rd(2'd1, d);
         chk($sformatf("R2/R8/R9 vector %0d status", i), d, {10'd0, VEC[i][5:0]});
      end
      rd(2'd2, d); chk("R8 clear register reads zero", d, 0);

      // R11 readback, R10 irq timing
      wr(2'd0, 16'h0001);
      rd(2'd0, d); chk("R11 enable readback", d, 16'h0001);
      chk("R10 irq low with no flags", irq, 0);
      ev_bus_err = 1'b1; @(negedge clk); ev_bus_err = 1'b0;
      chk("R10 irq not yet high in flag cycle", irq, 0);
      @(negedge clk);
      chk("R10 irq high one cycle later", irq, 1);
      wr(2'd2, 16'h0001);
      chk("R10 irq still high in clear cycle", irq, 1);
      @(negedge clk);
      chk("R10 irq low one cycle after clear", irq, 0);
      ev_xfer_done = 1'b1; @(negedge clk); ev_xfer_done = 1'b0;
      @(negedge clk);
      chk("R10 masked flag keeps irq low", irq, 0);
      wr(2'd0, 16'h0003);
      chk("R10 irq low in enable-write cycle", irq, 0);
      @(negedge clk);
      chk("R10 irq high after enable", irq, 1);
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'h003F);

      // R3 R4 watermark
      wr(2'd3, 16'h0005);
      rd(2'd3, d); chk("R11 watermark readback", d, 16'h0005);
      start_xfer();
      pix(16'd4, 1'b1);
      rd(2'd1, d); chk("R3 other line end no watermark", d, 0);
      pix(16'd5, 1'b0);
      rd(2'd1, d); chk("R3 mid-line pixel no watermark", d, 0);
      pix(16'd5, 1'b1);
      rd(2'd1, d); chk("R3 watermark line end sets bit 2", d, 16'h0004);
      wr(2'd2, 16'h0004);
      pix(16'd5, 1'b1);
      rd(2'd1, d); chk("R4 no second watermark in transfer", d, 0);
      start_xfer();
      pix(16'd5, 1'b1);
      rd(2'd1, d); chk("R4 rearmed watermark fires", d, 16'h0004);
      wr(2'd2, 16'h003F);

      // R5 R6 R7 lookup-table conflicts
      lut_mem_rdata = 32'hA5A5_0001;
      lut_busy = 1'b1; cpu_lut_req = 1'b1;
      #1;
      chk("R7 conflict blocks memory strobe", lut_mem_req, 0);
      chk("R7 conflict read returns zero", cpu_lut_rdata, 0);
      @(negedge clk);
      cpu_lut_req = 1'b0; lut_busy = 1'b0;
      rd(2'd1, d); chk("R5 conflict during table load", d, 16'h0008);
      wr(2'd2, 16'h0008);
      cpu_lut_req = 1'b1;
      #1;
      chk("R7 idle access forwarded", lut_mem_req, 1);
      chk("R7 idle access read data", cpu_lut_rdata, 32'hA5A5_0001);
      @(negedge clk);
      cpu_lut_req = 1'b0;
      rd(2'd1, d); chk("R7 idle access sets no flag", d, 0);
      xfer_busy = 1'b1; cpu_lut_req = 1'b1;
      #1;
      chk("R7 conflict during transfer blocked", lut_mem_req, 0);
      @(negedge clk);
      cpu_lut_req = 1'b0; xfer_busy = 1'b0;
      rd(2'd1, d); chk("R6 conflict during transfer", d, 16'h0008);

      summary();
      $finish;
   end
endmodule